// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block prepares the second operand of an arithmetic/logic unit. The operand passes through a shift or rotate chosen by a 3-bit kind code, by an amount that may come from an instruction field or from the low byte of a register. The block also produces a carry-out, the last bit moved out of the word, which flag-setting move and logical operations load into their carry flag. The path is purely combinational, so the shifted value is ready in the same cycle as the instruction that needs it.

Five operations are provided: shift left with zero fill, shift right with zero fill, shift right with copies of the sign bit, rotate right, and a one-place rotate right that brings the incoming carry flag into the top bit. Amounts of zero, amounts equal to the word width and larger amounts each have their own, exactly defined results. Decoding of kind and amount sits in a small control module that hands a struct of select strobes to the datapath.

Top module: `opnd_shifter`

## Requirements
- R1: Both outputs are a combinational function of the present inputs; a change on any input shows at the outputs with no clock edge.
- R2: Kind code 0 (shift left) with amount n in 1..31 gives operand<<n with zero fill and carry-out equal to operand bit 32-n.
- R3: Kind code 1 (logical shift right) with amount n in 1..31 gives operand>>n with zero fill and carry-out equal to operand bit n-1.
- R4: Kind code 2 (arithmetic shift right) with amount n in 1..31 fills the top n positions with operand bit 31; carry-out is operand bit n-1.
- R5: Kind code 3 (rotate right) with amount n in 1..31 gives (operand>>n)|(operand<<(32-n)); carry-out is operand bit n-1.
- R6: Kind code 4 (extended rotate) gives {carryIn, operand[31:1]} and carry-out operand bit 0, whatever the amount.
- R7: For kind codes 0 to 3, amount 0 passes the operand unchanged and carry-out equals carryIn.
- R8: Kind codes 0 and 1 with amount 32 give zero, carry-out operand bit 0 (left) or bit 31 (right); with amount above 32 they give zero and carry-out 0.
- R9: Kind code 2 with amount 32 or more gives 32 copies of operand bit 31, which is also the carry-out.
- R10: Kind code 3 with a nonzero amount that is a multiple of 32 leaves the operand unchanged with carry-out bit 31; any other amount above 32 acts as the amount modulo 32.
- R11: Kind codes 5, 6 and 7 pass the operand unchanged with carry-out equal to carryIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | Operand to shift |
| shiftKind | input | 3 | Operation code: 0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 extended rotate |
| shiftAmt | input | 8 | Unsigned shift amount (immediate or register low byte) |
| carryIn | input | 1 | Present carry flag |
| result | output | 32 | Shifted operand |
| carryOut | output | 1 | Last bit moved out, or carryIn when nothing moves |

## Verification
The value path and the carry path are both settled from the same inputs at once, and the hardest cases are those where both leave the ordinary route together: an amount of exactly 32, a rotate by 64, or an extended rotate with a large amount, where the word is forced or passed while the carry comes from a fixed bit or from carryIn. These are provoked by directed tasks that sweep every amount from 0 to 40 plus a few large ones for each kind, on patterns with the top and bottom bits set differently, and by random operands and amounts. Each pair of outputs is judged against a bench model written from the requirements.

// File: rtl/opnd_shifter_pkg.sv
package opnd_shifter_pkg;

  // Operation codes seen on the shiftKind port.
  localparam logic [2:0] KIND_LSL = 3'd0;
  localparam logic [2:0] KIND_LSR = 3'd1;
  localparam logic [2:0] KIND_ASR = 3'd2;
  localparam logic [2:0] KIND_ROR = 3'd3;
  localparam logic [2:0] KIND_RRX = 3'd4;

  // What fills the positions vacated at the top of the right shifter.
  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_SIGN = 2'd1,
    FILL_WRAP = 2'd2
  } fill_e;

  // Which value drives the result port.
  typedef enum logic [2:0] {
    OUT_PASS  = 3'd0,
    OUT_SHIFT = 3'd1,
    OUT_ZERO  = 3'd2,
    OUT_SIGN  = 3'd3,
    OUT_EXT   = 3'd4
  } outSel_e;

  // Which bit drives the carry-out port.
  typedef enum logic [2:0] {
    CY_IN    = 3'd0,
    CY_PICK  = 3'd1,
    CY_LSB   = 3'd2,
    CY_MSB   = 3'd3,
    CY_CLEAR = 3'd4
  } carrySel_e;

  // Strobes from decode to datapath.
  typedef struct packed {
    outSel_e   outSel;
    carrySel_e carrySel;
    fill_e     fill;
    logic      reverse;
  } shCtrl_t;

endpackage

// File: rtl/opnd_shifter_ctrl.sv
module opnd_shifter_ctrl
  import opnd_shifter_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = 8,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic [2:0]       shiftKind,
  input  logic [AMT_W-1:0] shiftAmt,
  output shCtrl_t          ctrl,
  output logic [SH_W-1:0]  shiftBy
);

  localparam logic [AMT_W-1:0] WIDTH_AMT = AMT_W'(DATA_W);

  logic amtZero;
  logic amtInRange;
  logic amtAtWidth;
  logic rotLowZero;

  always_comb begin
    amtZero    = (shiftAmt == '0);
    amtInRange = (shiftAmt < WIDTH_AMT);
    amtAtWidth = (shiftAmt == WIDTH_AMT);
    rotLowZero = (shiftAmt[SH_W-1:0] == '0);
  end

  always_comb begin
    ctrl.outSel   = OUT_PASS;
    ctrl.carrySel = CY_IN;
    ctrl.fill     = FILL_ZERO;
    ctrl.reverse  = 1'b0;
    shiftBy       = shiftAmt[SH_W-1:0];

    unique case (shiftKind)
      KIND_LSL, KIND_LSR: begin
        ctrl.reverse = (shiftKind == KIND_LSL);
        if (amtZero) begin
          ctrl.outSel   = OUT_PASS;
          ctrl.carrySel = CY_IN;
        end else if (amtInRange) begin
          ctrl.outSel   = OUT_SHIFT;
          ctrl.carrySel = CY_PICK;
        end else if (amtAtWidth) begin
          ctrl.outSel   = OUT_ZERO;
          ctrl.carrySel = (shiftKind == KIND_LSL) ? CY_LSB : CY_MSB;
        end else begin
          ctrl.outSel   = OUT_ZERO;
          ctrl.carrySel = CY_CLEAR;
        end
      end
      KIND_ASR: begin
        ctrl.fill = FILL_SIGN;
        if (amtZero) begin
          ctrl.outSel   = OUT_PASS;
          ctrl.carrySel = CY_IN;
        end else if (amtInRange) begin
          ctrl.outSel   = OUT_SHIFT;
          ctrl.carrySel = CY_PICK;
        end else begin
          ctrl.outSel   = OUT_SIGN;
          ctrl.carrySel = CY_MSB;
        end
      end
      KIND_ROR: begin
        ctrl.fill = FILL_WRAP;
        if (amtZero) begin
          ctrl.outSel   = OUT_PASS;
          ctrl.carrySel = CY_IN;
        end else if (rotLowZero) begin
          // full turns: word unchanged, last bit out is the top bit
          ctrl.outSel   = OUT_PASS;
          ctrl.carrySel = CY_MSB;
        end else begin
          ctrl.outSel   = OUT_SHIFT;
          ctrl.carrySel = CY_PICK;
        end
      end
      KIND_RRX: begin
        ctrl.outSel   = OUT_EXT;
        ctrl.carrySel = CY_LSB;
      end
      default: begin
        ctrl.outSel   = OUT_PASS;
        ctrl.carrySel = CY_IN;
      end
    endcase
  end

  // Decode must never request a stage shift by zero: that case is a pass.
  always_comb begin
    if (ctrl.outSel == OUT_SHIFT) begin
      p_shift_nonzero_r7: assert (shiftBy != '0)
        else $error("shift requested with zero stage amount");
    end
  end

endmodule

// File: rtl/opnd_shifter_dp.sv
module opnd_shifter_dp
  import opnd_shifter_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opA,
  input  logic              carryIn,
  input  shCtrl_t           ctrl,
  input  logic [SH_W-1:0]   shiftBy,
  output logic [DATA_W-1:0] result,
  output logic              carryOut
);

  function automatic logic [DATA_W-1:0] bitRev(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  logic [DATA_W-1:0] revIn;
  logic [DATA_W-1:0] stageVal [SH_W+1];
  logic              fillBit;
  logic [DATA_W-1:0] shifted;
  logic [SH_W-1:0]   pickIdx;
  logic              pickBit;

  always_comb begin
    revIn   = ctrl.reverse ? bitRev(opA) : opA;
    fillBit = (ctrl.fill == FILL_SIGN) ? opA[DATA_W-1] : 1'b0;
  end

  assign stageVal[0] = revIn;

  // One right-shift stage per amount bit; stage k moves by 2**k.
  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    logic [DATA_W-1:0] moved;
    always_comb begin
      if (ctrl.fill == FILL_WRAP)
        moved = {stageVal[k][STEP-1:0], stageVal[k][DATA_W-1:STEP]};
      else
        moved = {{STEP{fillBit}}, stageVal[k][DATA_W-1:STEP]};
    end
    assign stageVal[k+1] = shiftBy[k] ? moved : stageVal[k];
  end

  always_comb begin
    shifted = ctrl.reverse ? bitRev(stageVal[SH_W]) : stageVal[SH_W];
    pickIdx = shiftBy - SH_W'(1);
    pickBit = revIn[pickIdx];
  end

  always_comb begin
    unique case (ctrl.outSel)
      OUT_SHIFT: result = shifted;
      OUT_ZERO:  result = '0;
      OUT_SIGN:  result = {DATA_W{opA[DATA_W-1]}};
      OUT_EXT:   result = {carryIn, opA[DATA_W-1:1]};
      default:   result = opA;
    endcase
    unique case (ctrl.carrySel)
      CY_PICK:  carryOut = pickBit;
      CY_LSB:   carryOut = opA[0];
      CY_MSB:   carryOut = opA[DATA_W-1];
      CY_CLEAR: carryOut = 1'b0;
      default:  carryOut = carryIn;
    endcase
  end

  // A wrapping shift only permutes bits.
  always_comb begin
    if (ctrl.outSel == OUT_SHIFT && ctrl.fill == FILL_WRAP) begin
      p_rotate_keeps_ones_r5: assert ($countones(result) == $countones(opA))
        else $error("rotate changed the number of set bits");
    end
  end

endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import opnd_shifter_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AMT_W  = 8
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [2:0]        shiftKind,
  input  logic [AMT_W-1:0]  shiftAmt,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              carryOut
);

  localparam int unsigned SH_W = $clog2(DATA_W);

  shCtrl_t         ctrlBus;
  logic [SH_W-1:0] shiftBy;

  opnd_shifter_ctrl #(
    .DATA_W (DATA_W),
    .AMT_W  (AMT_W)
  ) u_ctrl (
    .shiftKind (shiftKind),
    .shiftAmt  (shiftAmt),
    .ctrl      (ctrlBus),
    .shiftBy   (shiftBy)
  );

  opnd_shifter_dp #(
    .DATA_W (DATA_W)
  ) u_dp (
    .opA      (opA),
    .carryIn  (carryIn),
    .ctrl     (ctrlBus),
    .shiftBy  (shiftBy),
    .result   (result),
    .carryOut (carryOut)
  );

  // Port-level checks on the whole path.
  always_comb begin
    if (shiftKind == KIND_LSL && shiftAmt != '0) begin
      p_lsl_low_clear_r2: assert (result[0] == 1'b0)
        else $error("left shift left bit 0 set");
    end
    if (shiftKind == KIND_LSR && shiftAmt != '0) begin
      p_lsr_top_clear_r3: assert (result[DATA_W-1] == 1'b0)
        else $error("logical right shift left top bit set");
    end
    if (shiftKind == KIND_ASR) begin
      p_asr_sign_kept_r4: assert (result[DATA_W-1] == opA[DATA_W-1])
        else $error("arithmetic shift lost the sign");
    end
    if (shiftKind == KIND_RRX) begin
      p_ext_rot_r6: assert (result[DATA_W-1] == carryIn && carryOut == opA[0])
        else $error("extended rotate wrong");
    end
    if (shiftKind <= KIND_ROR && shiftAmt == '0) begin
      p_zero_pass_r7: assert (result == opA && carryOut == carryIn)
        else $error("zero amount did not pass through");
    end
    if (shiftKind > KIND_RRX) begin
      p_spare_pass_r11: assert (result == opA && carryOut == carryIn)
        else $error("spare code did not pass through");
    end
  end

endmodule

// File: tb/opnd_shifter_tb.sv
module opnd_shifter_tb;

  logic        clk = 1'b0;
  logic [31:0] opA;
  logic [2:0]  shiftKind;
  logic [7:0]  shiftAmt;
  logic        carryIn;
  logic [31:0] result;
  logic        carryOut;

  int testsRun  = 0;
  int testsFail = 0;
  int cycles    = 0;

  always #4 clk = ~clk;   // 125 MHz

  opnd_shifter u_dut (
    .opA       (opA),
    .shiftKind (shiftKind),
    .shiftAmt  (shiftAmt),
    .carryIn   (carryIn),
    .result    (result),
    .carryOut  (carryOut)
  );

  // Model built from the requirements: returns {carry, value}.
  function automatic logic [32:0] model(input logic [2:0] k, input logic [7:0] n,
                                        input logic [31:0] x, input logic c);
    logic [31:0] v;
    logic        co;
    int          m;
    v = x; co = c;
    case (k)
      3'd0: if (n != 0) begin
        if (n < 32) begin v = x << n; co = x[32-n]; end
        else if (n == 32) begin v = 0; co = x[0]; end
        else begin v = 0; co = 1'b0; end
      end
      3'd1: if (n != 0) begin
        if (n < 32) begin v = x >> n; co = x[n-1]; end
        else if (n == 32) begin v = 0; co = x[31]; end
        else begin v = 0; co = 1'b0; end
      end
      3'd2: if (n != 0) begin
        if (n < 32) begin v = $unsigned($signed(x) >>> n); co = x[n-1]; end
        else begin v = {32{x[31]}}; co = x[31]; end
      end
      3'd3: if (n != 0) begin
        m = n % 32;
        if (m == 0) begin v = x; co = x[31]; end
        else begin v = (x >> m) | (x << (32 - m)); co = x[m-1]; end
      end
      3'd4: begin v = {c, x[31:1]}; co = x[0]; end
      default: ;
    endcase
    return {co, v};
  endfunction

  task automatic check(input string req, input logic [32:0] got, input logic [32:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFail++;
      $display("FAIL %s: kind=%0d amt=%0d op=%h cin=%b got c=%b v=%h exp c=%b v=%h",
               req, shiftKind, shiftAmt, opA, carryIn, got[32], got[31:0], exp[32], exp[31:0]);
    end
  endtask

  // Drive on the falling edge, sample 2 ns later, away from the rising edge.
  task automatic apply(input string req, input logic [2:0] k, input logic [7:0] n,
                       input logic [31:0] x, input logic c);
    @(negedge clk);
    shiftKind = k; shiftAmt = n; opA = x; carryIn = c;
    #2;
    check(req, {carryOut, result}, model(k, n, x, c));
  endtask

  function automatic string reqFor(input logic [2:0] k, input logic [7:0] n);
    if (k > 3'd4) return "R11";
    if (k == 3'd4) return "R6";
    if (n == 0) return "R7";
    if (n < 32) case (k)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      default: return "R5";
    endcase
    case (k)
      3'd0, 3'd1: return "R8";
      3'd2: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic t_idle_state;
    // all-zero inputs give a zero word and clear carry (R7)
    apply("R7", 3'd0, 8'd0, 32'h0, 1'b0);
    check("R7", {carryOut, result}, 33'h0);
  endtask

  task automatic t_combinational;
    // R1: outputs follow an input change with no clock edge in between
    @(negedge clk);
    shiftKind = 3'd1; shiftAmt = 8'd4; opA = 32'hF000_000F; carryIn = 1'b0;
    #1;
    check("R1", {carryOut, result}, model(3'd1, 8'd4, 32'hF000_000F, 1'b0));
    opA = 32'h0000_0018;
    #1;
    check("R1", {carryOut, result}, model(3'd1, 8'd4, 32'h0000_0018, 1'b0));
    shiftAmt = 8'd5;
    #1;
    check("R1", {carryOut, result}, model(3'd1, 8'd5, 32'h0000_0018, 1'b0));
  endtask

  task automatic t_sweep_kind(input logic [2:0] k);
    // R2..R5 and R7..R10: every amount 0..40, plus large values
    logic [31:0] pats [4] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_3C5A, 32'hFFFF_FFFF};
    logic [7:0]  bigs [4] = '{8'd63, 8'd64, 8'd96, 8'd255};
    for (int p = 0; p < 4; p++) begin
      for (int n = 0; n <= 40; n++)
        apply(reqFor(k, 8'(n)), k, 8'(n), pats[p], p[0]);
      for (int b = 0; b < 4; b++)
        apply(reqFor(k, bigs[b]), k, bigs[b], pats[p], ~p[0]);
    end
  endtask

  task automatic t_ext_rotate;
    // R6: amount plays no part, carry flag enters at the top
    for (int n = 0; n < 256; n += 17) begin
      apply("R6", 3'd4, 8'(n), 32'h1234_5679, 1'b1);
      apply("R6", 3'd4, 8'(n), 32'h8765_4320, 1'b0);
    end
    apply("R6", 3'd4, 8'd0, 32'h0000_0001, 1'b0);
    check("R6", {carryOut, result}, {1'b1, 32'h0});
  endtask

  task automatic t_spare_codes;
    // R11: codes 5..7 pass the word and carry
    for (int k = 5; k < 8; k++) begin
      apply("R11", 3'(k), 8'd3, 32'hDEAD_BEEF, 1'b1);
      apply("R11", 3'(k), 8'd40, 32'h0F0F_0F0F, 1'b0);
    end
  endtask

  task automatic t_fixed_values;
    // hand-worked values
    apply("R2", 3'd0, 8'd1, 32'h8000_0001, 1'b0);
    check("R2", {carryOut, result}, {1'b1, 32'h0000_0002});
    apply("R4", 3'd2, 8'd4, 32'h8000_0010, 1'b0);
    check("R4", {carryOut, result}, {1'b0, 32'hF800_0001});
    apply("R5", 3'd3, 8'd8, 32'h1234_5680, 1'b0);
    check("R5", {carryOut, result}, {1'b1, 32'h8012_3456});
    apply("R8", 3'd1, 8'd32, 32'h8000_0000, 1'b0);
    check("R8", {carryOut, result}, {1'b1, 32'h0});
    apply("R10", 3'd3, 8'd36, 32'h0000_000F, 1'b0);
    check("R10", {carryOut, result}, {1'b1, 32'hF000_0000});
  endtask

  task automatic t_random;
    for (int i = 0; i < 2000; i++) begin
      logic [2:0]  k;
      logic [7:0]  n;
      k = 3'($urandom_range(0, 7));
      n = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 33));
      apply(reqFor(k, n), k, n, $urandom, 1'($urandom));
    end
  endtask

  initial begin
    opA = '0; shiftKind = '0; shiftAmt = '0; carryIn = 1'b0;
    repeat (2) @(posedge clk);
    t_idle_state();
    t_combinational();
    for (int k = 0; k < 4; k++) t_sweep_kind(3'(k));
    t_ext_rotate();
    t_spare_codes();
    t_fixed_values();
    t_random();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      testsRun++;
      testsFail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
      $finish;
    end
  end

endmodule